// File: doc/BRIEF.md
# Single-Packet GMII Byte Bridge

This block links a byte-wide gigabit media interface to an 8-bit processor I/O bus. It holds one received frame and one frame waiting to be sent, each in its own internal byte buffer. The processor sees eight I/O locations at a base address set by a parameter. Through them it polls a status byte, reads the length of the held frame, pops received bytes one at a time, pushes bytes to send, and issues a send command.

On the line side the block samples a data-valid strobe with a byte lane, and drives an enable with a byte lane. Everything runs on one clock. The block exchanges raw bytes only. Framing symbols, checksums, lower rates and link management are left to software or to other logic.

There is only one slot in each direction. A frame that starts while the held frame is still unread is thrown away whole. Status flags clear at fixed points: the ready flag when the last held byte is read, and the done flag when the first byte of the next outgoing frame is pushed.

Top module: `gmii_pkt_bridge`

## Requirements
- R1: The block answers only when ioAddr[7:3] equals BASE_ADDR[7:3], and ioAddr[2:0] selects the offset. A read elsewhere returns 0x00, and a write elsewhere changes nothing. ioRdData is 0x00 whenever ioRd is low.
- R2: A read of offset 0 returns the status byte: bit 0 is rxReady, bit 1 is txDone, and bits 7:2 are zero. Both flags are 0 after reset.
- R3: rxReady stays set until a read of offset 4 returns the final byte of the held frame. The clock edge that ends that read clears it.
- R4: While rxReady is set, a read of offset 2 returns bits 7:0 of the held frame length, and a read of offset 3 returns bits 15:8.
- R5: While rxReady is set, each read of offset 4 returns the next held byte in arrival order, starting at byte 0. A read of offset 4 while rxReady is clear moves nothing.
- R6: A frame starts on a clock where gmiiRxDv is high after a clock where it was low. The frame keeps every byte sampled while gmiiRxDv stays high. rxReady sets on the edge that first samples gmiiRxDv low.
- R7: A frame whose first byte arrives while rxReady is set is discarded whole, even if rxReady clears part way through that frame. The held frame and its length stay unchanged.
- R8: A frame longer than DEPTH bytes keeps its first DEPTH bytes, and its length reads as DEPTH.
- R9: A write of offset 5 appends a byte to the transmit buffer. A write of offset 1 with bit 0 set starts a send. gmiiTxEn then goes high on the second edge after the command and stays high for exactly as many cycles as bytes were pushed. gmiiTxd carries those bytes in push order. gmiiTxd is 0x00 while gmiiTxEn is low.
- R10: A send command is ignored in three cases: bit 0 is clear, the transmit buffer is empty, or a frame is still being sent. Pushes are ignored while a frame is being sent.
- R11: txDone sets on the edge where gmiiTxEn falls, and the transmit buffer empties at the same edge. The next push clears txDone and becomes byte 0 of the next frame.
- R12: Reads of offsets 1, 5, 6 and 7 return 0x00. Writes to offsets 0, 2, 3, 4, 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the line side and the bus side |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 8 | I/O address |
| ioWrData | input | 8 | Write data |
| ioWr | input | 1 | Write strobe, one cycle per write |
| ioRd | input | 1 | Read strobe, one cycle per read |
| ioRdData | output | 8 | Read data, valid in the cycle ioRd is high |
| gmiiRxDv | input | 1 | Receive data valid |
| gmiiRxd | input | 8 | Receive byte |
| gmiiTxEn | output | 1 | Transmit enable |
| gmiiTxd | output | 8 | Transmit byte |

## Verification
The assertions assume that ioRd and ioWr are never high in the same cycle. They also assume that software never pushes more than DEPTH bytes before a send, and that gmiiRxDv is a clean level that changes only at clock edges. The stimulus keeps to these limits: each bus access drives exactly one strobe for one cycle, outgoing frames stay far below the buffer size, and receive frames are driven a whole byte per cycle with the strobe held steady across each byte. Only the truncation test goes past the receive buffer size, and the block is specified to handle that case.

// File: rtl/gmii_bridge_pkg.sv
package gmii_bridge_pkg;
  localparam int LEN_W = 16;

  typedef struct packed {
    logic rxFirst;
    logic rxNext;
    logic rxPop;
    logic txPush;
    logic txLoad;
    logic txShift;
    logic txClear;
  } bridgeStrobeT;
endpackage

// File: rtl/gmii_bridge_dp.sv
module gmii_bridge_dp
  import gmii_bridge_pkg::*;
#(
  parameter int DEPTH = 2048
) (
  input  logic               clk,
  input  logic               rstN,
  input  bridgeStrobeT       stb,
  input  logic [7:0]         rxByteIn,
  input  logic [7:0]         wrByte,
  output logic [LEN_W-1:0]   rxLen,
  output logic [7:0]         rxHead,
  output logic [7:0]         txOut,
  output logic               rxLastOut,
  output logic               txLastOut,
  output logic               txEmpty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LEN_W-1:0] CAP = LEN_W'(DEPTH);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [7:0] rxMem [DEPTH];
  logic [7:0] txMem [DEPTH];
  logic [LEN_W-1:0] rxCnt, rxRdPtr, txWrPtr, txRdPtr;
  logic [7:0] txdQ;
  logic rxRoom;

  assign rxRoom = rxCnt < CAP;

  always_ff @(posedge clk) begin
    if (stb.rxFirst) rxMem[0] <= rxByteIn;
    else if (stb.rxNext && rxRoom) rxMem[rxCnt[AW-1:0]] <= rxByteIn;
    if (stb.txPush) txMem[txWrPtr[AW-1:0]] <= wrByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxCnt   <= '0;
      rxRdPtr <= '0;
      txWrPtr <= '0;
      txRdPtr <= '0;
      txdQ    <= '0;
    end else begin
      if (stb.rxFirst) rxCnt <= ONE;
      else if (stb.rxNext && rxRoom) rxCnt <= rxCnt + ONE;

      if (stb.rxFirst) rxRdPtr <= '0;
      else if (stb.rxPop) rxRdPtr <= rxLastOut ? '0 : rxRdPtr + ONE;

      if (stb.txClear) txWrPtr <= '0;
      else if (stb.txPush) txWrPtr <= txWrPtr + ONE;

      if (stb.txLoad) txRdPtr <= '0;
      else if (stb.txShift) txRdPtr <= txRdPtr + ONE;

      txdQ <= stb.txShift ? txMem[txRdPtr[AW-1:0]] : 8'h00;
    end
  end

  assign rxLen     = rxCnt;
  assign rxHead    = rxMem[rxRdPtr[AW-1:0]];
  assign rxLastOut = (rxRdPtr == rxCnt - ONE);
  assign txLastOut = (txRdPtr == txWrPtr - ONE);
  assign txEmpty   = (txWrPtr == '0);
  assign txOut     = txdQ;

  // R8: the captured count never passes the buffer size
  p_len_cap_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxCnt <= CAP);
endmodule

// File: rtl/gmii_bridge_ctrl.sv
module gmii_bridge_ctrl
  import gmii_bridge_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR = 8'h40
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       ioAddr,
  input  logic [7:0]       ioWrData,
  input  logic             ioWr,
  input  logic             ioRd,
  input  logic             rxDv,
  input  logic [LEN_W-1:0] rxLen,
  input  logic [7:0]       rxHead,
  input  logic             rxLast,
  input  logic             txLast,
  input  logic             txEmpty,
  output bridgeStrobeT     stb,
  output logic [7:0]       ioRdData,
  output logic             txEn
);
  logic hit;
  logic [2:0] off;
  logic rxDvQ, capturing, rxReady, sending, txEnQ, txDone;
  logic busy, rdPop, push, go;

  assign hit   = (ioAddr[7:3] == BASE_ADDR[7:3]);
  assign off   = ioAddr[2:0];
  assign busy  = sending | txEnQ;
  assign rdPop = ioRd & hit & (off == 3'd4) & rxReady;
  assign push  = ioWr & hit & (off == 3'd5) & ~busy;
  assign go    = ioWr & hit & (off == 3'd1) & ioWrData[0] & ~busy & ~txEmpty;

  always_comb begin
    stb.rxFirst = rxDv & ~rxDvQ & ~rxReady;
    stb.rxNext  = capturing & rxDv;
    stb.rxPop   = rdPop;
    stb.txPush  = push;
    stb.txLoad  = go;
    stb.txShift = sending;
    stb.txClear = txEnQ & ~sending;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxDvQ     <= 1'b0;
      capturing <= 1'b0;
      rxReady   <= 1'b0;
      sending   <= 1'b0;
      txEnQ     <= 1'b0;
      txDone    <= 1'b0;
    end else begin
      rxDvQ <= rxDv;
      if (stb.rxFirst) capturing <= 1'b1;
      else if (capturing && !rxDv) begin
        capturing <= 1'b0;
        rxReady   <= 1'b1;
      end
      if (rdPop && rxLast) rxReady <= 1'b0;

      if (go) sending <= 1'b1;
      else if (sending && txLast) sending <= 1'b0;
      txEnQ <= sending;

      if (stb.txClear) txDone <= 1'b1;
      else if (push && txEmpty) txDone <= 1'b0;
    end
  end

  always_comb begin
    ioRdData = 8'h00;
    if (ioRd && hit) begin
      unique case (off)
        3'd0:    ioRdData = {6'b0, txDone, rxReady};
        3'd2:    ioRdData = rxLen[7:0];
        3'd3:    ioRdData = rxLen[15:8];
        3'd4:    ioRdData = rxHead;
        default: ioRdData = 8'h00;
      endcase
    end
  end

  assign txEn = txEnQ;

  // R6: the ready flag rises only after the valid strobe was sampled low
  p_ready_after_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> !$past(rxDv));
  // R3: the ready flag holds until a data read is made
  p_ready_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxReady && !(ioRd && hit && off == 3'd4) |=> rxReady);
  // R7: no capture begins while a frame is held
  p_no_capture_when_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxReady |=> !$rose(capturing));
  // R11: done rises together with the enable falling
  p_done_on_fall_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEnQ) |-> $rose(txDone));
endmodule

// File: rtl/gmii_pkt_bridge.sv
module gmii_pkt_bridge
  import gmii_bridge_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR = 8'h40,
  parameter int         DEPTH     = 2048
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] ioAddr,
  input  logic [7:0] ioWrData,
  input  logic       ioWr,
  input  logic       ioRd,
  output logic [7:0] ioRdData,
  input  logic       gmiiRxDv,
  input  logic [7:0] gmiiRxd,
  output logic       gmiiTxEn,
  output logic [7:0] gmiiTxd
);
  bridgeStrobeT stb;
  logic [LEN_W-1:0] rxLen;
  logic [7:0] rxHead;
  logic rxLast, txLast, txEmpty;

  gmii_bridge_ctrl #(.BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData),
    .ioWr(ioWr), .ioRd(ioRd), .rxDv(gmiiRxDv), .rxLen(rxLen),
    .rxHead(rxHead), .rxLast(rxLast), .txLast(txLast), .txEmpty(txEmpty),
    .stb(stb), .ioRdData(ioRdData), .txEn(gmiiTxEn)
  );

  gmii_bridge_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rxByteIn(gmiiRxd),
    .wrByte(ioWrData), .rxLen(rxLen), .rxHead(rxHead), .txOut(gmiiTxd),
    .rxLastOut(rxLast), .txLastOut(txLast), .txEmpty(txEmpty)
  );

  // R9: the byte lane is quiet whenever the enable is low
  p_txd_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !gmiiTxEn |-> gmiiTxd == 8'h00);
endmodule

// File: tb/gmii_pkt_bridge_bench.sv
`timescale 1ns/1ps
module gmii_pkt_bridge_bench;
  localparam logic [7:0] BASE = 8'h40;
  localparam int DEPTH = 2048;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] bAddr = '0, bWd = '0, bRxd = '0;
  logic bWr = 1'b0, bRd = 1'b0, bDv = 1'b0;
  logic [7:0] ioRdData, gmiiTxd;
  logic gmiiTxEn;

  int vectors = 0;
  int errs = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  gmii_pkt_bridge #(.BASE_ADDR(BASE), .DEPTH(DEPTH)) u_gmii_pkt_bridge (
    .clk(clk), .rstN(rstN), .ioAddr(bAddr), .ioWrData(bWd), .ioWr(bWr),
    .ioRd(bRd), .ioRdData(ioRdData), .gmiiRxDv(bDv), .gmiiRxd(bRxd),
    .gmiiTxEn(gmiiTxEn), .gmiiTxd(gmiiTxd)
  );

  // reference model state
  bit mReady, mCap, mDone, mDvPrev, expTxEn;
  logic [7:0] expTxd;
  logic [7:0] mRxQ[$];
  logic [7:0] mTxBuf[$];
  logic [7:0] mLine[$];
  int mLen, mRdIdx;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mReady = 0; mCap = 0; mDone = 0; mDvPrev = 0; expTxEn = 0; expTxd = 0;
      mRxQ.delete(); mTxBuf.delete(); mLine.delete(); mLen = 0; mRdIdx = 0;
    end else begin
      bit hitB, busy, readyPre;
      logic [2:0] offB;
      hitB = (bAddr[7:3] == BASE[7:3]);
      offB = bAddr[2:0];
      busy = (mLine.size() > 0) || expTxEn;
      readyPre = mReady;
      if (mLine.size() > 0) begin
        expTxEn = 1; expTxd = mLine.pop_front();
      end else begin
        if (expTxEn) begin mDone = 1; mTxBuf.delete(); end
        expTxEn = 0; expTxd = 0;
      end
      if (bWr && hitB && offB == 3'd1 && bWd[0] && !busy && mTxBuf.size() > 0)
        mLine = mTxBuf;
      if (bWr && hitB && offB == 3'd5 && !busy) begin
        if (mTxBuf.size() == 0) mDone = 0;
        mTxBuf.push_back(bWd);
      end
      if (bRd && hitB && offB == 3'd4 && readyPre) begin
        mRdIdx++;
        if (mRdIdx == mLen) mReady = 0;
      end
      if (bDv && !mDvPrev && !readyPre) begin
        mCap = 1; mRxQ.delete(); mRxQ.push_back(bRxd);
      end else if (mCap && bDv) begin
        if (mRxQ.size() < DEPTH) mRxQ.push_back(bRxd);
      end else if (mCap && !bDv) begin
        mCap = 0; mReady = 1; mLen = mRxQ.size(); mRdIdx = 0;
      end
      mDvPrev = bDv;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    #3;
    if (rstN && !finished) begin
      chk("R9 tx enable", {7'b0, gmiiTxEn}, {7'b0, expTxEn});
      chk("R9 tx byte", gmiiTxd, expTxd);
      if (!bRd) chk("R1 idle read", ioRdData, 8'h00);
      else if (bAddr[7:3] != BASE[7:3]) chk("R1 foreign read", ioRdData, 8'h00);
      else begin
        case (bAddr[2:0])
          3'd0: chk("R2 R3 R11 status", ioRdData, {6'b0, mDone, mReady});
          3'd2: if (mReady) chk("R4 len low", ioRdData, mLen[7:0]);
          3'd3: if (mReady) chk("R4 len high", ioRdData, mLen[15:8]);
          3'd4: if (mReady) chk("R5 data", ioRdData, mRxQ[mRdIdx]);
          default: chk("R12 write-only/reserved read", ioRdData, 8'h00);
        endcase
      end
    end
  end

  task automatic ioIdle(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bWr = 0; bRd = 0; bAddr = 0; bWd = 0;
    end
  endtask
  task automatic ioW(logic [7:0] addr, logic [7:0] d);
    @(negedge clk); bAddr = addr; bWd = d; bWr = 1; bRd = 0;
  endtask
  task automatic ioR(logic [7:0] addr);
    @(negedge clk); bAddr = addr; bWd = 0; bWr = 0; bRd = 1;
  endtask
  task automatic rdExpect(logic [7:0] addr, logic [7:0] exp, string tag);
    ioR(addr); #3; chk(tag, ioRdData, exp);
  endtask
  task automatic rxFrame(int n, int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bDv = 1; bRxd = 8'((seed + i * 7) & 255);
    end
    @(negedge clk); bDv = 0; bRxd = 0;
  endtask
  task automatic drain(int n);
    for (int i = 0; i < n; i++) begin ioR(BASE + 4); ioR(BASE + 0); end
    ioIdle();
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1; errs++; vectors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R2 reset state
    rdExpect(BASE + 0, 8'h00, "R2 reset status");
    ioIdle();
    // R5: data reads with nothing held move nothing
    ioR(BASE + 4); ioR(BASE + 4); ioIdle();
    // R6 R3 R4 R5: single frame, status polled during and after
    fork
      rxFrame(5, 3);
      begin repeat (8) ioR(BASE + 0); ioIdle(); end
    join
    ioIdle(2);
    rdExpect(BASE + 2, 8'h05, "R4 length low");
    rdExpect(BASE + 3, 8'h00, "R4 length high");
    drain(4);
    rdExpect(BASE + 0, 8'h01, "R3 flag before last byte");
    ioR(BASE + 4);
    rdExpect(BASE + 0, 8'h00, "R3 flag after last byte");
    ioIdle();
    // R7: back-to-back frames, second dropped
    rxFrame(6, 40);
    rxFrame(4, 90);
    ioIdle(3);
    rdExpect(BASE + 2, 8'h06, "R7 held length kept");
    rdExpect(BASE + 4, 8'd40, "R7 held data kept");
    // R7: frame begins while held, flag clears mid-frame: still dropped
    fork
      rxFrame(12, 120);
      begin ioIdle(2); drain(5); end
    join
    ioIdle(2);
    rdExpect(BASE + 0, 8'h00, "R7 mid-frame clear drops frame");
    rxFrame(3, 200);
    ioIdle(2);
    rdExpect(BASE + 2, 8'h03, "R6 next frame accepted");
    drain(3);
    // R10: send with empty buffer ignored
    ioW(BASE + 1, 8'h01); ioIdle(4);
    // R9 R10 R1 R12: pushes, ignored writes and commands
    ioW(BASE + 5, 8'hA1); ioW(BASE + 5, 8'hB2);
    ioW(8'h80 | 8'h05, 8'h5A);
    ioW(BASE + 6, 8'hFF); ioW(BASE + 2, 8'h77);
    ioW(BASE + 5, 8'hC3); ioW(BASE + 5, 8'hD4);
    ioR(BASE + 5); ioR(BASE + 1); ioR(BASE + 7); ioR(8'h10);
    ioW(BASE + 1, 8'h00); ioIdle(3);
    ioW(BASE + 1, 8'h01);
    ioW(BASE + 5, 8'hEE); ioW(BASE + 1, 8'h01);
    ioIdle(8);
    // R11: done set, cleared on first push
    rdExpect(BASE + 0, 8'h02, "R11 done after send");
    ioW(BASE + 5, 8'h11);
    rdExpect(BASE + 0, 8'h00, "R11 done cleared by push");
    ioW(BASE + 5, 8'h22); ioW(BASE + 1, 8'hFF);
    ioIdle(6);
    // R8: overlong frame truncated
    rxFrame(DEPTH + 3, 7);
    ioIdle(2);
    rdExpect(BASE + 2, 8'(DEPTH & 255), "R8 truncated length low");
    rdExpect(BASE + 3, 8'((DEPTH >> 8) & 255), "R8 truncated length high");
    for (int i = 0; i < DEPTH; i++) ioR(BASE + 4);
    rdExpect(BASE + 0, 8'h02, "R8 flag clears after DEPTH reads");
    ioIdle(3);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule